// File: doc/BRIEF.md
# Variable Audio Delay Line

This block produces a delayed copy of an 8-bit sample stream. Every enabled clock writes the incoming sample into a circular buffer. The buffer is a dual-port RAM, and a free-running counter supplies its write address. In the same clock, the second port reads the slot that lies a programmable number of positions behind the write position.

The delay is set at run time through a 9-bit offset input. The read port is registered, so each output sample appears one clock after the edge that fetched it. The current write position is also brought out, for observation or for aligning other logic.

Address and data widths are parameters. The default buffer holds 512 samples of 8 bits. Reset returns only the write position to zero. The buffer contents survive reset, so the output is meaningful only once the programmed delay's worth of samples has been written since reset.

Top module: `audio_delay_line`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `wr_pos` becomes 0 at that edge. No sample is written and `dly_out` is not updated during that edge.
- R2: On each rising edge with `rst_n` high and `en` high, `wr_pos` increases by exactly one. It wraps from 511 to 0.
- R3: On a rising edge with `en` low, nothing is written to the buffer, whatever `smp_in` carries. Both `wr_pos` and `dly_out` keep their values.
- R4: With `lag` = d in the range 1 to 511, after an enabled edge `dly_out` equals the sample written d enabled edges before that edge. This holds once at least d samples have been written since reset.
- R5: With `lag` = 0, the read and write slots coincide. The read returns the slot's contents from before this edge's write, which is the sample written 512 enabled edges earlier.
- R6: A new `lag` value takes effect at the first enabled edge at which it is present. No extra settling clock is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the write position |
| en | input | 1 | Advance enable: write, read and step when high |
| smp_in | input | 8 | Incoming sample |
| lag | input | 9 | Delay in samples, 0 meaning a full buffer length |
| dly_out | output | 8 | Registered delayed sample |
| wr_pos | output | 9 | Current write position |

## Verification
The assertions assume two things. First, `en` and `rst_n` are stable around the clock edge. Second, the one-sample-delay property only applies after two consecutive enabled cycles out of reset, because before that the slot being read may hold stale data from before reset.

The stimulus drives all inputs on the falling edge. It switches `lag` between runs without pausing, and it inserts disabled gaps that carry distinctive sample values. A mid-run reset shows the write position restarting. The reference model counts only samples written since the last reset, so output comparisons are skipped until the programmed delay has been filled.

// File: rtl/dl_pkg.sv
// Package: shared defaults for the delay line.
// Assumes: widths are overridden at the top when another size is needed.
package dl_pkg;
    localparam int DL_ADDR_W = 9;
    localparam int DL_DATA_W = 8;
endpackage

// File: rtl/dl_wr_counter.sv
// Module: free-running write position counter.
// Assumes: step is already qualified by reset; wraps naturally at 2**AW.
module dl_wr_counter #(
    parameter int AW = dl_pkg::DL_ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] pos
);
    // Advance the position on each qualified step; synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= '0;
        else if (step)
            pos <= pos + 1'b1;
    end
endmodule

// File: rtl/dl_rd_addr.sv
// Module: read position generator, trailing the write position by an offset.
// Assumes: modulo 2**AW arithmetic is the intended circular behaviour.
module dl_rd_addr #(
    parameter int AW = dl_pkg::DL_ADDR_W
) (
    input  logic [AW-1:0] wpos,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] rpos
);
    // Subtract the offset; the carry out is dropped to wrap around the buffer.
    always_comb begin
        rpos = wpos - offset;
    end
endmodule

// File: rtl/dl_dpram.sv
// Module: simple dual-port RAM, one write port and one registered read port.
// Assumes: a read of the slot being written returns the previous contents.
//          Contents are not initialised or cleared.
module dl_dpram #(
    parameter int AW = dl_pkg::DL_ADDR_W,
    parameter int DW = dl_pkg::DL_DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store the sample on a qualified write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read port: register the old contents of the addressed slot.
    always_ff @(posedge clk) begin
        if (re)
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/audio_delay_line.sv
// Module: variable delay line over a circular dual-port buffer.
// Assumes: lag is sampled at each enabled edge; lag of 0 means a full lap.
//          Reset clears only the write position.
module audio_delay_line #(
    parameter int AW = dl_pkg::DL_ADDR_W,
    parameter int DW = dl_pkg::DL_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] smp_in,
    input  logic [AW-1:0] lag,
    output logic [DW-1:0] dly_out,
    output logic [AW-1:0] wr_pos
);
    logic          go;
    logic [AW-1:0] rd_pos;

    // Qualify activity: nothing moves or is stored while in reset.
    always_comb begin
        go = en && rst_n;
    end

    dl_wr_counter #(.AW(AW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (go),
        .pos   (wr_pos)
    );

    dl_rd_addr #(.AW(AW)) u_radr (
        .wpos   (wr_pos),
        .offset (lag),
        .rpos   (rd_pos)
    );

    dl_dpram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (go),
        .waddr (wr_pos),
        .wdata (smp_in),
        .re    (go),
        .raddr (rd_pos),
        .rdata (dly_out)
    );
endmodule

// File: rtl/audio_delay_line_chk.sv
// Module: property checker for the delay line, attached by bind.
// Assumes: inputs are settled at each rising edge.
module audio_delay_line_chk #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [DW-1:0] smp_in,
    input logic [AW-1:0] lag,
    input logic [DW-1:0] dly_out,
    input logic [AW-1:0] wr_pos
);
    // R1: reset returns the write position to zero.
    p_reset_pos_r1: assert property (@(posedge clk)
        !rst_n |=> wr_pos == '0);

    // R2: each enabled edge advances the position by one, wrapping.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> wr_pos == $past(wr_pos) + 1'b1);

    // R3: a disabled edge leaves position and output untouched.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(wr_pos) && $stable(dly_out));

    // R4: a lag of one returns the sample written at the previous enabled edge.
    p_lag_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en && $past(en) && $past(rst_n) && lag == 1
        |=> dly_out == $past(smp_in, 2));
endmodule

bind audio_delay_line audio_delay_line_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .smp_in  (smp_in),
    .lag     (lag),
    .dly_out (dly_out),
    .wr_pos  (wr_pos)
);

// File: tb/tb_audio_delay_line.sv
module tb_audio_delay_line;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int DEPTH = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] smp_in = '0;
    logic [AW-1:0] lag = '0;
    logic [DW-1:0] dly_out;
    logic [AW-1:0] wr_pos;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state.
    int   hist[$];
    int   exp_pos = 0;
    int   exp_out = 0;
    bit   exp_valid = 1'b0;
    string tag_out = "R4";
    string tag_pos = "R2";

    audio_delay_line #(.AW(AW), .DW(DW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .smp_in  (smp_in),
        .lag     (lag),
        .dly_out (dly_out),
        .wr_pos  (wr_pos)
    );

    always #5 clk = ~clk;

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cycles);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One clock: drive inputs, advance the model at the edge, compare after.
    task automatic cyc(bit r, bit e, int s, int d);
        int deff;
        rst_n  = r;
        en     = e;
        smp_in = DW'(s);
        lag    = AW'(d);
        @(posedge clk);
        cycles++;
        if (!r) begin
            hist.delete();
            exp_pos   = 0;
            exp_valid = 1'b0;
        end else if (e) begin
            deff = (d == 0) ? DEPTH : d;
            if (hist.size() >= deff) begin
                exp_out   = hist[hist.size() - deff];
                exp_valid = 1'b1;
            end else begin
                exp_valid = 1'b0;
            end
            hist.push_back(s & 255);
            if (hist.size() > 2 * DEPTH) void'(hist.pop_front());
            exp_pos = (exp_pos + 1) % DEPTH;
        end
        @(negedge clk);
        check(!r ? "R1" : (e ? tag_pos : "R3"), int'(wr_pos), exp_pos);
        if (r && exp_valid)
            check(e ? tag_out : "R3", int'(dly_out), exp_out);
    endtask

    function automatic int pat(int i);
        return (i * 37 + 11) & 255;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        @(negedge clk);
        // R1: reset state, with en high to show it is overridden.
        cyc(0, 1, 99, 5);
        cyc(0, 0, 0, 5);

        // R4: fixed lag of 5.
        tag_out = "R4";
        for (int i = 0; i < 40; i++) cyc(1, 1, pat(i), 5);

        // R6: lag switched on the fly.
        tag_out = "R6";
        for (int i = 0; i < 10; i++) cyc(1, 1, pat(i + 100), 1);
        for (int i = 0; i < 30; i++) cyc(1, 1, pat(i + 200), 17);

        // R3: disabled gaps with distinctive samples; output and position hold.
        held = int'(dly_out);
        for (int i = 0; i < 6; i++) cyc(1, 0, 255 - i, 3);
        check("R3", int'(dly_out), held);
        tag_out = "R4";
        for (int i = 0; i < 12; i++) cyc(1, 1, pat(i + 300), 3);
        for (int i = 0; i < 4; i++) cyc(1, 0, 170, 2);
        for (int i = 0; i < 8; i++) cyc(1, 1, pat(i + 350), 2);

        // R5 and R2 wrap: run past a full lap with lag 0.
        tag_out = "R5";
        for (int i = 0; i < 560; i++) cyc(1, 1, pat(i + 400), 0);

        // R4: longest lag.
        tag_out = "R4";
        for (int i = 0; i < 30; i++) cyc(1, 1, pat(i + 1000), 511);

        // R1: mid-run reset, then fresh alignment.
        cyc(0, 1, 7, 3);
        check("R1", int'(wr_pos), 0);
        for (int i = 0; i < 20; i++) cyc(1, 1, pat(i + 1100), 3);

        finish_run();
    end
endmodule